// File: doc/BRIEF.md
# Target Address Calculation Unit

This block turns the addressing bits of a three-byte or four-byte instruction into a 20-bit effective address. It also reports how that address is to be used: as the operand value itself, as the location of the operand, or as the location of a word that holds the operand's address. The caller supplies the instruction word, the program counter (already advanced past the current instruction), the base register and the index register. The block reads the addressing flags (n, i, x, b, p, e) and picks one of four address sources: a plain displacement, base plus displacement, PC plus signed displacement, or a long 20-bit field. It then optionally adds the index register.

Instructions with both n and i clear come from the older, narrower machine. For these the b, p and e bits are not decoded as flags. They form the upper part of a 15-bit direct address, which can still be indexed. Flag combinations that have no meaning are reported on an illegal flag; the address is still produced. Memory access and the indirect fetch itself are left to the caller. With the default parameter setting, results appear one clock after the request. Setting `REG_OUT` to 0 makes the path purely combinational.

Top module: `tac_unit`

## Requirements
- R1: Fields of `instr_word`: opcode [31:26], n [25], i [24], x [23], b [22], p [21], e [20], short displacement [19:8], long address [19:0]. Output `opmode` encodes 0 = immediate (n=0,i=1), 1 = simple (n=1,i=1, or n=i=0), 2 = indirect (n=1,i=0).
- R2: With n or i set, e=0 and b=p=0, the target address is the 12-bit displacement zero-extended.
- R3: With n or i set and e=1, the target address is the 20-bit long field; b and p are then ignored unless both are set.
- R4: With n or i set, e=0, b=1 and p=0, the target address is base_reg plus the zero-extended displacement.
- R5: With n or i set, e=0, b=0 and p=1, the target address is pc_next plus the sign-extended displacement.
- R6: With x=1, index_reg is added to the address formed by any direct, relative or long mode.
- R7: With n=i=0, bits [22:8] form a 15-bit direct address, zero-extended, plus index_reg when x=1. The mode is simple and the illegal flag stays low.
- R8: x=1 together with immediate or indirect mode raises `illegal`.
- R9: b=p=1 with n or i set raises `illegal`. The target address is then the zero-extended displacement, with no index added.
- R10: Every address sum wraps modulo 2^20.
- R11: With REG_OUT=1, results for a request appear one clock later with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low on the next clock, while `target_addr` keeps its last value.
- R12: While reset is asserted, `out_valid`, `target_addr`, `opmode` and `illegal` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| instr_word | input | 32 | Instruction, first byte in [31:24] |
| pc_next | input | 20 | Program counter past the instruction |
| base_reg | input | 20 | Base register |
| index_reg | input | 20 | Index register |
| out_valid | output | 1 | Result strobe |
| target_addr | output | 20 | Effective target address |
| opmode | output | 2 | Operand use: 0 immediate, 1 simple, 2 indirect |
| illegal | output | 1 | Meaningless flag combination |

## Verification
Requests are chosen so that each address source gives a different sum from the same register values, so a wrong source selection shows up as a wrong address. PC-relative cases with positive and negative displacements separate sign extension from zero extension. Sums placed next to 2^20 expose missing wrap-around. The legacy cases use set b, p and e bits inside the 15-bit field together with nonzero base and PC values, which shows whether those bits were wrongly taken as flags. The illegal cases pair indexing with each non-simple mode, and also set both relative bits.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int unsigned TAC_AW  = 20;
  localparam int unsigned TAC_DW  = 12;
  localparam int unsigned TAC_OPW = 6;

  typedef enum logic [1:0] {
    OPM_IMM    = 2'd0,
    OPM_SIMPLE = 2'd1,
    OPM_INDIR  = 2'd2
  } opm_e;

  typedef enum logic [1:0] {
    BASE_NONE = 2'd0,
    BASE_BREG = 2'd1,
    BASE_PC   = 2'd2
  } base_sel_e;

  typedef enum logic [1:0] {
    OFF_DISP_Z = 2'd0,
    OFF_DISP_S = 2'd1,
    OFF_LONG   = 2'd2,
    OFF_LEGACY = 2'd3
  } off_sel_e;

  typedef struct packed {
    logic n;
    logic i;
    logic x;
    logic b;
    logic p;
    logic e;
  } tac_flags_t;
endpackage

// File: rtl/tac_field_split.sv
module tac_field_split
  import tac_pkg::*;
#(
  parameter int unsigned AW  = TAC_AW,
  parameter int unsigned DW  = TAC_DW,
  parameter int unsigned OPW = TAC_OPW,
  localparam int unsigned IW = OPW + 6 + AW,
  localparam int unsigned LW = DW + 3
) (
  input  logic [IW-1:0] instr,
  output tac_flags_t    flags,
  output logic [DW-1:0] disp,
  output logic [AW-1:0] addr_long,
  output logic [LW-1:0] addr_legacy
);
  localparam int unsigned FLAG_TOP = IW - OPW - 1;
  localparam int unsigned DISP_TOP = IW - OPW - 7;

  logic unused_opcode;
  assign unused_opcode = ^instr[IW-1 -: OPW];

  assign flags.n     = instr[FLAG_TOP];
  assign flags.i     = instr[FLAG_TOP-1];
  assign flags.x     = instr[FLAG_TOP-2];
  assign flags.b     = instr[FLAG_TOP-3];
  assign flags.p     = instr[FLAG_TOP-4];
  assign flags.e     = instr[FLAG_TOP-5];
  assign disp        = instr[DISP_TOP -: DW];
  assign addr_long   = instr[AW-1:0];
  assign addr_legacy = instr[FLAG_TOP-3 -: LW];
endmodule

// File: rtl/tac_mode_decode.sv
module tac_mode_decode
  import tac_pkg::*;
(
  input  tac_flags_t flags,
  output opm_e       mode,
  output base_sel_e  base_sel,
  output off_sel_e   off_sel,
  output logic       use_index,
  output logic       illegal
);
  logic legacy;
  logic bp_bad;

  always_comb begin
    legacy = ~flags.n & ~flags.i;
    bp_bad = ~legacy & flags.b & flags.p;

    unique case ({flags.n, flags.i})
      2'b01:   mode = OPM_IMM;
      2'b10:   mode = OPM_INDIR;
      default: mode = OPM_SIMPLE;
    endcase

    base_sel  = BASE_NONE;
    off_sel   = OFF_DISP_Z;
    use_index = flags.x;

    if (legacy) begin
      off_sel = OFF_LEGACY;
    end else if (bp_bad) begin
      use_index = 1'b0;
    end else if (flags.e) begin
      off_sel = OFF_LONG;
    end else if (flags.b) begin
      base_sel = BASE_BREG;
    end else if (flags.p) begin
      base_sel = BASE_PC;
      off_sel  = OFF_DISP_S;
    end

    illegal = bp_bad | (flags.x & (flags.n ^ flags.i));
  end
endmodule

// File: rtl/tac_addr_gen.sv
module tac_addr_gen
  import tac_pkg::*;
#(
  parameter int unsigned AW = TAC_AW,
  parameter int unsigned DW = TAC_DW,
  localparam int unsigned LW = DW + 3
) (
  input  base_sel_e     base_sel,
  input  off_sel_e      off_sel,
  input  logic          use_index,
  input  logic [AW-1:0] pc_val,
  input  logic [AW-1:0] breg_val,
  input  logic [AW-1:0] xreg_val,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] addr_long,
  input  logic [LW-1:0] addr_legacy,
  output logic [AW-1:0] ta
);
  logic [AW-1:0] base_term;
  logic [AW-1:0] off_term;
  logic [AW-1:0] idx_term;

  always_comb begin
    unique case (base_sel)
      BASE_BREG: base_term = breg_val;
      BASE_PC:   base_term = pc_val;
      default:   base_term = '0;
    endcase

    unique case (off_sel)
      OFF_DISP_S: off_term = {{(AW-DW){disp[DW-1]}}, disp};
      OFF_LONG:   off_term = addr_long;
      OFF_LEGACY: off_term = {{(AW-LW){1'b0}}, addr_legacy};
      default:    off_term = {{(AW-DW){1'b0}}, disp};
    endcase

    idx_term = use_index ? xreg_val : '0;
    ta       = base_term + off_term + idx_term;
  end
endmodule

// File: rtl/tac_unit.sv
module tac_unit
  import tac_pkg::*;
#(
  parameter int unsigned AW      = TAC_AW,
  parameter int unsigned DW      = TAC_DW,
  parameter int unsigned OPW     = TAC_OPW,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned IW     = OPW + 6 + AW,
  localparam int unsigned LW     = DW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] instr_word,
  input  logic [AW-1:0] pc_next,
  input  logic [AW-1:0] base_reg,
  input  logic [AW-1:0] index_reg,
  output logic          out_valid,
  output logic [AW-1:0] target_addr,
  output logic [1:0]    opmode,
  output logic          illegal
);
  tac_flags_t    flags;
  logic [DW-1:0] disp;
  logic [AW-1:0] addr_long;
  logic [LW-1:0] addr_legacy;
  opm_e          dec_mode;
  base_sel_e     base_sel;
  off_sel_e      off_sel;
  logic          use_index;
  logic          dec_ill;
  logic [AW-1:0] gen_ta;

  tac_field_split #(.AW(AW), .DW(DW), .OPW(OPW)) u_split (
    .instr       (instr_word),
    .flags       (flags),
    .disp        (disp),
    .addr_long   (addr_long),
    .addr_legacy (addr_legacy)
  );

  tac_mode_decode u_dec (
    .flags     (flags),
    .mode      (dec_mode),
    .base_sel  (base_sel),
    .off_sel   (off_sel),
    .use_index (use_index),
    .illegal   (dec_ill)
  );

  tac_addr_gen #(.AW(AW), .DW(DW)) u_gen (
    .base_sel    (base_sel),
    .off_sel     (off_sel),
    .use_index   (use_index),
    .pc_val      (pc_next),
    .breg_val    (base_reg),
    .xreg_val    (index_reg),
    .disp        (disp),
    .addr_long   (addr_long),
    .addr_legacy (addr_legacy),
    .ta          (gen_ta)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic          vld_d, vld_q;
      logic [AW-1:0] ta_d, ta_q;
      logic [1:0]    md_d, md_q;
      logic          il_d, il_q;
      logic          load_en;

      always_comb begin
        load_en = in_valid;
        vld_d   = in_valid;
        ta_d    = gen_ta;
        md_d    = dec_mode;
        il_d    = dec_ill;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          ta_q  <= '0;
          md_q  <= '0;
          il_q  <= 1'b0;
        end else begin
          vld_q <= vld_d;
          if (load_en) begin
            ta_q <= ta_d;
            md_q <= md_d;
            il_q <= il_d;
          end
        end
      end

      assign out_valid   = vld_q;
      assign target_addr = ta_q;
      assign opmode      = md_q;
      assign illegal     = il_q;

      p_out_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_out_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(target_addr)));
    end else begin : g_comb
      assign out_valid   = in_valid;
      assign target_addr = gen_ta;
      assign opmode      = dec_mode;
      assign illegal     = dec_ill;
    end
  endgenerate

  p_legacy_simple_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !instr_word[IW-OPW-1] && !instr_word[IW-OPW-2])
      |-> (dec_mode == OPM_SIMPLE && !dec_ill));
  p_index_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr_word[IW-OPW-3] &&
     (instr_word[IW-OPW-1] != instr_word[IW-OPW-2])) |-> dec_ill);
  p_bp_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (instr_word[IW-OPW-1] || instr_word[IW-OPW-2]) &&
     instr_word[IW-OPW-4] && instr_word[IW-OPW-5]) |-> dec_ill);
  p_ext_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (instr_word[IW-OPW-1] || instr_word[IW-OPW-2]) &&
     instr_word[IW-OPW-6] && !instr_word[IW-OPW-3] &&
     !(instr_word[IW-OPW-4] && instr_word[IW-OPW-5]))
      |-> (gen_ta == instr_word[AW-1:0]));
endmodule

// File: tb/sim_tac_unit.sv
`timescale 1ns/1ps
module sim_tac_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr_word;
  logic [19:0] pc_next, base_reg, index_reg;
  logic        out_valid;
  logic [19:0] target_addr;
  logic [1:0]  opmode;
  logic        illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [19:0] ta;
    logic [1:0]  md;
    logic        il;
    string       tag;
  } exp_t;
  exp_t sb[$];

  localparam logic [1:0] M_IMM = 2'd0, M_SIM = 2'd1, M_IND = 2'd2;

  always #2 clk = ~clk;

  tac_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr_word(instr_word),
    .pc_next(pc_next), .base_reg(base_reg), .index_reg(index_reg),
    .out_valid(out_valid), .target_addr(target_addr), .opmode(opmode),
    .illegal(illegal)
  );

  function automatic logic [31:0] mk3(input logic n, i, x, b, p, e,
                                      input logic [11:0] d);
    return {6'h0C, n, i, x, b, p, e, d, 8'h00};
  endfunction

  function automatic logic [31:0] mk4(input logic n, i, x, b, p,
                                      input logic [19:0] a);
    return {6'h12, n, i, x, b, p, 1'b1, a};
  endfunction

  task automatic send(input logic [31:0] w, input logic [19:0] pc, bs, ix,
                      input logic [19:0] eta, input logic [1:0] emd,
                      input logic eil, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid   = 1'b1;
    instr_word = w;
    pc_next    = pc;
    base_reg   = bs;
    index_reg  = ix;
    e.ta = eta; e.md = emd; e.il = eil; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected result: ta=%h expected no output", target_addr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (target_addr !== e.ta || opmode !== e.md || illegal !== e.il) begin
          fails++;
          $display("FAIL %s: ta=%h md=%0d il=%0b expected ta=%h md=%0d il=%0b",
                   e.tag, target_addr, opmode, illegal, e.ta, e.md, e.il);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr_word = '0;
    pc_next = '0; base_reg = '0; index_reg = '0;
    repeat (3) @(negedge clk);
    checks++;  // R12 reset state
    if (out_valid !== 1'b0 || target_addr !== '0 || opmode !== 2'd0 || illegal !== 1'b0) begin
      fails++;
      $display("FAIL R12 reset: vld=%0b ta=%h md=%0d il=%0b expected all zero",
               out_valid, target_addr, opmode, illegal);
    end
    rst_n = 1'b1;

    send(mk3(1,1,0,1,0,0,12'h003), 20'h04000, 20'h00033, 20'h00000, 20'h00036, M_SIM, 0, "R4 base rel");
    send(mk3(1,0,0,0,0,0,12'hABC), 20'h04000, 20'h00033, 20'h00000, 20'h00ABC, M_IND, 0, "R2 direct indirect");
    send(mk3(0,1,0,0,1,0,12'h010), 20'h01000, 20'h00033, 20'h00000, 20'h01010, M_IMM, 0, "R5 pc rel pos");
    send(mk3(1,1,0,0,1,0,12'hFF0), 20'h01000, 20'h00033, 20'h00000, 20'h00FF0, M_SIM, 0, "R5 pc rel neg");
    send(mk3(1,1,0,0,1,0,12'hFF8), 20'h00004, 20'h00033, 20'h00000, 20'hFFFFC, M_SIM, 0, "R10 pc wrap");
    send(mk4(1,1,0,0,0,20'h12345), 20'h01000, 20'h00500, 20'h00010, 20'h12345, M_SIM, 0, "R3 long");
    send(mk4(1,1,0,1,0,20'h12345), 20'h01000, 20'h00500, 20'h00010, 20'h12345, M_SIM, 0, "R3 long b ignored");
    send(mk4(1,1,1,0,0,20'h12345), 20'h01000, 20'h00500, 20'h00010, 20'h12355, M_SIM, 0, "R6 long indexed");
    send(mk3(1,1,1,1,0,0,12'h020), 20'h01000, 20'h00100, 20'h00005, 20'h00125, M_SIM, 0, "R6 base indexed");
    send(mk3(1,1,0,1,0,0,12'h020), 20'h01000, 20'hFFFF0, 20'h00000, 20'h00010, M_SIM, 0, "R10 base wrap");
    send({6'h00, 2'b00, 1'b0, 15'h7ABC, 8'h00}, 20'h22222, 20'h11111, 20'h00300, 20'h07ABC, M_SIM, 0, "R7 legacy");
    send({6'h00, 2'b00, 1'b1, 15'h0100, 8'h00}, 20'h22222, 20'h11111, 20'h00022, 20'h00122, M_SIM, 0, "R7 legacy indexed");
    send(mk3(0,1,1,0,0,0,12'h005), 20'h01000, 20'h00100, 20'h00001, 20'h00006, M_IMM, 1, "R8 imm indexed");
    send(mk3(1,0,1,0,0,0,12'h005), 20'h01000, 20'h00100, 20'h00002, 20'h00007, M_IND, 1, "R8 ind indexed");
    send(mk3(1,1,1,1,1,0,12'h040), 20'h01000, 20'h00100, 20'h00002, 20'h00040, M_SIM, 1, "R9 b and p");
    send(mk4(0,1,0,0,0,20'h00007), 20'h01000, 20'h00100, 20'h00002, 20'h00007, M_IMM, 0, "R1 long immediate");

    @(negedge clk);
    in_valid = 1'b0;
    instr_word = mk3(1,1,0,0,1,0,12'h111);
    @(negedge clk);
    @(negedge clk);
    checks++;  // R11 idle cycle drops strobe and holds address
    if (out_valid !== 1'b0 || target_addr !== 20'h00007) begin
      fails++;
      $display("FAIL R11 idle: vld=%0b ta=%h expected vld=0 ta=00007", out_valid, target_addr);
    end
    checks++;  // R11 every request produced one result
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R11 missing results: %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule